// File: doc/BRIEF.md
# Pixel-Array Timing Readout with Trigger Latency Buffer

This block gathers the per-crossing timing results of a 16-pixel matrix and turns them into a framed word stream. Each pixel delivers, once per bunch-crossing clock, a hit flag, a 10-bit arrival-time code and a 9-bit time-over-threshold code. The block runs in one of two modes, chosen at reset.

In diagnostic mode the block ignores triggers. On every crossing it sends the current result of one configured pixel. In triggered mode every pixel writes its result into its own circular latency buffer on every crossing. A level-1 accept reads back the entry that is exactly the programmed latency old. The block then emits one word for each enabled pixel that had a hit in that crossing, in ascending pixel order, and closes the frame with a trailer word that carries the crossing number. Accepts that arrive during a readout wait in a short queue of read addresses. A sticky flag reports any accept lost because that queue was full.

Top module: `pix_timing_readout`

## Requirements
- R1: Reset behaviour.
  - On a clock edge where `rst` is high, `out_vld`, `out_trl`, `out_data` and `out_ovf` all go to zero.
  - The pending-trigger queue is emptied.
  - The crossing counter and the buffer write position return to zero. The first edge after reset is crossing 0.
- R2: Diagnostic-mode word stream.
  - In diagnostic mode (`cfg_trig_mode` latched as 0), every crossing produces one word, one clock after the sample is presented, with `out_vld`=1 and `out_trl`=0.
  - Word layout: bit 23 is the hit flag, bits 22:19 the pixel index given by `cfg_diag_pix`, bits 18:9 the arrival code and bits 8:0 the time-over-threshold code.
  - The word is sent whether or not the pixel has a hit.
- R3: In diagnostic mode `l1a` has no effect. No trailer appears and `out_ovf` stays low.
- R4: Latency read-back.
  - In triggered mode (latched 1), an `l1a` sampled at crossing t with latency L (0 to 31) reports the samples taken at crossing t−L. This holds provided the read starts within 32−L crossings.
  - With an idle block and an empty queue, the word for pixel p appears after edge t+2+p.
- R5: Word selection and order.
  - A triggered frame holds a word only for pixels whose `cfg_pix_en` bit is set and whose stored hit flag is 1.
  - Words come in ascending pixel index, with bit 23 set and the same layout as in R2.
  - No word is emitted for any other pixel.
- R6: Frame trailer.
  - Every accepted trigger ends its frame with one trailer word, with `out_vld`=1 and `out_trl`=1. The trailer comes even when the frame has no hit words.
  - The trailer's bits 11:0 hold (t−L) mod 4096 and its upper bits are zero.
  - With an idle block it appears after edge t+18.
- R7: Accepts that arrive during a readout are queued, up to 4 pending. They are served in arrival order, each producing its own frame.
- R8: Overflow.
  - An `l1a` sampled while 4 accepts are pending is dropped. This applies even on a cycle where one is being taken from the queue.
  - A dropped accept sets `out_ovf`, which stays high until reset.
- R9: `cfg_trig_mode` and `cfg_latency` are captured only on reset edges. Changing them without a reset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous active-high reset; also latches mode and latency |
| cfg_trig_mode | input | 1 | 1 = triggered mode, 0 = diagnostic mode (taken at reset) |
| cfg_diag_pix | input | 4 | Pixel streamed in diagnostic mode |
| cfg_pix_en | input | 16 | Per-pixel enable for triggered readout |
| cfg_latency | input | 5 | Trigger latency in crossings (taken at reset) |
| l1a | input | 1 | Level-1 accept pulse |
| hit_vld | input | 16 | Per-pixel hit flag for this crossing |
| hit_toa | input | 160 | Per-pixel arrival codes, pixel p at bits 10p+9:10p |
| hit_tot | input | 144 | Per-pixel time-over-threshold codes, pixel p at bits 9p+8:9p |
| out_vld | output | 1 | Output word valid |
| out_trl | output | 1 | Output word is a frame trailer |
| out_data | output | 24 | Output word |
| out_ovf | output | 1 | Sticky trigger-queue overflow flag |

## Verification
On every cycle, the checker confirms five properties:
- diagnostic mode emits a non-trailer word on every crossing and never a trailer;
- every triggered word carries a hit flag for a pixel that was enabled;
- within a frame the pixel indices strictly rise, and a trailer is followed by a quiet cycle;
- the overflow flag never drops;
- the latched mode and latency never move outside reset.

Other behaviours only the bench's scenarios can show, by replaying the stream against its behavioural model. These are whether the returned codes belong to exactly the crossing L earlier, the trailer's crossing number, and the order of queued frames. Also left to the bench are which accepts a full queue drops, stale entries read after a long backlog, and the latency boundaries 0 and 31.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
  // Readout sequencer states
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SCAN  = 2'd1,
    SQ_TRAIL = 2'd2
  } seq_state_t;
endpackage

// File: rtl/ptr_pixel_buffer.sv
// One pixel's circular latency store: one write port, one registered read
// port, read-first, written so block RAM can be inferred.
module ptr_pixel_buffer #(
  parameter int DW    = 20,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/ptr_l1_queue.sv
// Small FIFO of pending trigger read requests. Full is judged before any pop.
module ptr_l1_queue #(
  parameter int EW     = 17,
  parameter int QDEPTH = 4,
  localparam int QAW   = (QDEPTH > 1) ? $clog2(QDEPTH) : 1,
  localparam int CW    = $clog2(QDEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [EW-1:0] push_data,
  input  logic          pop,
  output logic [EW-1:0] head,
  output logic          empty,
  output logic          full
);
  logic [EW-1:0]  slot [QDEPTH];
  logic [QAW-1:0] wr_idx, rd_idx;
  logic [CW-1:0]  count;
  logic           do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(QDEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = slot[rd_idx];

  always_ff @(posedge clk) begin
    if (do_push) slot[wr_idx] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_idx <= '0;
      rd_idx <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_idx <= (wr_idx == QAW'(QDEPTH - 1)) ? '0 : wr_idx + 1'b1;
      if (do_pop)  rd_idx <= (rd_idx == QAW'(QDEPTH - 1)) ? '0 : rd_idx + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ptr_readout_seq.sv
// Walks the snapshot of all pixels one index per cycle and frames the output.
module ptr_readout_seq
  import ptr_pkg::*;
#(
  parameter int N_PIX  = 16,
  parameter int TOA_W  = 10,
  parameter int TOT_W  = 9,
  parameter int BX_W   = 12,
  localparam int PIX_W  = $clog2(N_PIX),
  localparam int SW     = 1 + TOA_W + TOT_W,
  localparam int WORD_W = 1 + PIX_W + TOA_W + TOT_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                q_empty,
  input  logic [BX_W-1:0]     q_bx,
  input  logic [N_PIX*SW-1:0] samples,
  input  logic [N_PIX-1:0]    pix_en,
  output logic                pop,
  output logic                seq_vld,
  output logic                seq_trl,
  output logic [WORD_W-1:0]   seq_word
);
  seq_state_t       st;
  logic [PIX_W-1:0] idx;
  logic [BX_W-1:0]  bx_hold;
  logic [SW-1:0]    cur;

  assign pop = (st == SQ_IDLE) && !q_empty;
  assign cur = samples[int'(idx)*SW +: SW];

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_IDLE;
      idx      <= '0;
      bx_hold  <= '0;
      seq_vld  <= 1'b0;
      seq_trl  <= 1'b0;
      seq_word <= '0;
    end else begin
      seq_vld  <= 1'b0;
      seq_trl  <= 1'b0;
      seq_word <= '0;
      case (st)
        SQ_IDLE: if (!q_empty) begin
          bx_hold <= q_bx;
          idx     <= '0;
          st      <= SQ_SCAN;
        end
        SQ_SCAN: begin
          if (pix_en[idx] && cur[SW-1]) begin
            seq_vld  <= 1'b1;
            seq_word <= {1'b1, idx, cur[SW-2:0]};
          end
          if (idx == PIX_W'(N_PIX - 1)) st <= SQ_TRAIL;
          else idx <= idx + 1'b1;
        end
        SQ_TRAIL: begin
          seq_vld  <= 1'b1;
          seq_trl  <= 1'b1;
          seq_word <= WORD_W'(bx_hold);
          st       <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pix_timing_readout.sv
module pix_timing_readout #(
  parameter int N_PIX  = 16,
  parameter int TOA_W  = 10,
  parameter int TOT_W  = 9,
  parameter int DEPTH  = 32,
  parameter int QDEPTH = 4,
  parameter int BX_W   = 12,
  localparam int PIX_W  = $clog2(N_PIX),
  localparam int AW     = $clog2(DEPTH),
  localparam int SW     = 1 + TOA_W + TOT_W,
  localparam int WORD_W = 1 + PIX_W + TOA_W + TOT_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_trig_mode,
  input  logic [PIX_W-1:0]       cfg_diag_pix,
  input  logic [N_PIX-1:0]       cfg_pix_en,
  input  logic [AW-1:0]          cfg_latency,
  input  logic                   l1a,
  input  logic [N_PIX-1:0]       hit_vld,
  input  logic [N_PIX*TOA_W-1:0] hit_toa,
  input  logic [N_PIX*TOT_W-1:0] hit_tot,
  output logic                   out_vld,
  output logic                   out_trl,
  output logic [WORD_W-1:0]      out_data,
  output logic                   out_ovf
);
  // Mode and latency only move on reset edges
  logic          mode_q;
  logic [AW-1:0] lat_q;
  logic [AW-1:0] wr_ptr;
  logic [BX_W-1:0] bx_cnt;
  logic          ovf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= cfg_trig_mode;
      lat_q  <= cfg_latency;
      wr_ptr <= '0;
      bx_cnt <= '0;
    end else begin
      wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      bx_cnt <= bx_cnt + 1'b1;
    end
  end

  // Read address = write position minus latency, modulo depth
  logic [AW:0]     rd_calc;
  logic [AW-1:0]   rd_addr;
  logic [BX_W-1:0] bx_tag;
  always_comb begin
    rd_calc = {1'b0, wr_ptr} + (AW+1)'(DEPTH) - {1'b0, lat_q};
    if (rd_calc >= (AW+1)'(DEPTH)) rd_calc = rd_calc - (AW+1)'(DEPTH);
    rd_addr = rd_calc[AW-1:0];
    bx_tag  = bx_cnt - BX_W'(lat_q);
  end

  // Trigger queue
  logic            q_push, q_pop, q_empty, q_full;
  logic [AW+BX_W-1:0] q_head;
  assign q_push = mode_q && l1a;

  ptr_l1_queue #(.EW(AW + BX_W), .QDEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst(rst), .push(q_push), .push_data({rd_addr, bx_tag}),
    .pop(q_pop), .head(q_head), .empty(q_empty), .full(q_full)
  );

  always_ff @(posedge clk) begin
    if (rst) ovf_q <= 1'b0;
    else if (q_push && q_full) ovf_q <= 1'b1;
  end

  // Per-pixel latency buffers
  logic [N_PIX*SW-1:0] snap;
  for (genvar p = 0; p < N_PIX; p++) begin : g_pix
    ptr_pixel_buffer #(.DW(SW), .DEPTH(DEPTH)) u_buf (
      .clk(clk),
      .wr_en(!rst),
      .wr_addr(wr_ptr),
      .wr_data({hit_vld[p], hit_toa[p*TOA_W +: TOA_W], hit_tot[p*TOT_W +: TOT_W]}),
      .rd_en(q_pop),
      .rd_addr(q_head[AW+BX_W-1 -: AW]),
      .rd_data(snap[p*SW +: SW])
    );
  end

  logic              seq_vld, seq_trl;
  logic [WORD_W-1:0] seq_word;
  ptr_readout_seq #(.N_PIX(N_PIX), .TOA_W(TOA_W), .TOT_W(TOT_W), .BX_W(BX_W)) u_seq (
    .clk(clk), .rst(rst), .q_empty(q_empty), .q_bx(q_head[BX_W-1:0]),
    .samples(snap), .pix_en(cfg_pix_en), .pop(q_pop),
    .seq_vld(seq_vld), .seq_trl(seq_trl), .seq_word(seq_word)
  );

  // Diagnostic path: the selected pixel every crossing
  logic              diag_vld;
  logic [WORD_W-1:0] diag_word;
  logic [SW-1:0]     diag_sample;
  assign diag_sample = {hit_vld[cfg_diag_pix],
                        hit_toa[int'(cfg_diag_pix)*TOA_W +: TOA_W],
                        hit_tot[int'(cfg_diag_pix)*TOT_W +: TOT_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      diag_vld  <= 1'b0;
      diag_word <= '0;
    end else begin
      diag_vld  <= !mode_q;
      diag_word <= mode_q ? '0 : {diag_sample[SW-1], cfg_diag_pix, diag_sample[SW-2:0]};
    end
  end

  assign out_vld  = mode_q ? seq_vld  : diag_vld;
  assign out_trl  = mode_q && seq_trl;
  assign out_data = mode_q ? seq_word : diag_word;
  assign out_ovf  = ovf_q;
endmodule

// File: rtl/ptr_checker.sv
module ptr_checker #(
  parameter int N_PIX  = 16,
  parameter int AW     = 5,
  parameter int WORD_W = 24,
  localparam int PIX_W = $clog2(N_PIX)
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_q,
  input logic [AW-1:0]     lat_q,
  input logic [N_PIX-1:0]  cfg_pix_en,
  input logic              out_vld,
  input logic              out_trl,
  input logic [WORD_W-1:0] out_data,
  input logic              out_ovf
);
  logic [N_PIX-1:0] en_q;
  logic [PIX_W-1:0] last_pix;
  logic             in_frame;
  logic [PIX_W-1:0] pix;
  assign pix = out_data[WORD_W-2 -: PIX_W];

  always_ff @(posedge clk) begin
    en_q <= cfg_pix_en;
    if (rst) begin
      in_frame <= 1'b0;
      last_pix <= '0;
    end else if (out_vld && out_trl) begin
      in_frame <= 1'b0;
    end else if (out_vld && mode_q) begin
      in_frame <= 1'b1;
      last_pix <= pix;
    end
  end

  AST_DIAG_EVERY_BX: assert property (@(posedge clk) disable iff (rst)
    !mode_q |=> (out_vld && !out_trl)); // R2
  AST_DIAG_NO_TRAILER: assert property (@(posedge clk) disable iff (rst)
    !mode_q |-> !out_trl); // R3
  AST_TRIG_WORD_HIT: assert property (@(posedge clk) disable iff (rst)
    (mode_q && out_vld && !out_trl) |-> out_data[WORD_W-1]); // R5
  AST_TRIG_PIX_ENABLED: assert property (@(posedge clk) disable iff (rst)
    (mode_q && out_vld && !out_trl) |-> en_q[pix]); // R5
  AST_ASCENDING: assert property (@(posedge clk) disable iff (rst)
    (mode_q && in_frame && out_vld && !out_trl) |-> (pix > last_pix)); // R5
  AST_TRAILER_GAP: assert property (@(posedge clk) disable iff (rst)
    out_trl |=> !out_vld); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    out_ovf |=> out_ovf); // R8
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($stable(mode_q) && $stable(lat_q))); // R9
endmodule

bind pix_timing_readout ptr_checker #(.N_PIX(N_PIX), .AW(AW), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .mode_q(mode_q), .lat_q(lat_q), .cfg_pix_en(cfg_pix_en),
  .out_vld(out_vld), .out_trl(out_trl), .out_data(out_data), .out_ovf(out_ovf)
);

// File: tb/sim_pix_timing_readout.sv
module sim_pix_timing_readout;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 16;
  localparam int D  = 32;
  localparam int QD = 4;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic         b_rst = 1'b1, b_mode = 1'b0, b_l1a = 1'b0;
  logic [3:0]   b_dsel = 4'd5;
  logic [15:0]  b_en = 16'h0;
  logic [4:0]   b_lat = 5'd0;
  logic [15:0]  b_hit = 16'h0;
  logic [9:0]   b_toa [N];
  logic [8:0]   b_tot [N];
  logic [159:0] d_toa;
  logic [143:0] d_tot;
  logic         out_vld, out_trl, out_ovf;
  logic [23:0]  out_data;

  always_comb begin
    for (int p = 0; p < N; p++) begin
      d_toa[p*10 +: 10] = b_toa[p];
      d_tot[p*9 +: 9]   = b_tot[p];
    end
  end

  pix_timing_readout u0 (
    .clk(clk), .rst(b_rst), .cfg_trig_mode(b_mode), .cfg_diag_pix(b_dsel),
    .cfg_pix_en(b_en), .cfg_latency(b_lat), .l1a(b_l1a), .hit_vld(b_hit),
    .hit_toa(d_toa), .hit_tot(d_tot), .out_vld(out_vld), .out_trl(out_trl),
    .out_data(out_data), .out_ovf(out_ovf)
  );

  int checks = 0, failures = 0, trl_seen = 0, words_seen = 0;
  bit done = 0;

  // Behavioural reference state
  logic [19:0] m_mem [N][D];
  logic [19:0] m_rd [N];
  int m_q_addr[$], m_q_bx[$];
  int m_wptr = 0, m_bx = 0, m_mode = 0, m_lat = 0, m_st = 0, m_idx = 0, m_cur_bx = 0, m_ovf = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    logic [23:0] nd;
    bit nv, nt, was_full;
    int a;
    string lbl;
    nv = 0; nt = 0; nd = '0;
    if (b_rst) begin
      m_mode = b_mode; m_lat = b_lat; m_wptr = 0; m_bx = 0;
      m_q_addr.delete(); m_q_bx.delete(); m_st = 0; m_ovf = 0;
      lbl = "R1";
    end else begin
      if (m_mode == 0) begin
        nv = 1;
        nd = {b_hit[b_dsel], b_dsel, b_toa[b_dsel], b_tot[b_dsel]};
        lbl = "R2";
      end else begin
        was_full = (m_q_addr.size() == QD);
        case (m_st)
          0: if (m_q_addr.size() > 0) begin
               a = m_q_addr.pop_front();
               m_cur_bx = m_q_bx.pop_front();
               for (int p = 0; p < N; p++) m_rd[p] = m_mem[p][a];
               m_idx = 0; m_st = 1;
             end
          1: begin
               if (b_en[m_idx] && m_rd[m_idx][19]) begin
                 nv = 1;
                 nd = {1'b1, 4'(m_idx), m_rd[m_idx][18:0]};
               end
               if (m_idx == N-1) m_st = 2; else m_idx++;
             end
          default: begin
               nv = 1; nt = 1; nd = 24'(m_cur_bx); m_st = 0;
             end
        endcase
        if (b_l1a) begin
          if (was_full) m_ovf = 1;
          else begin
            m_q_addr.push_back((m_wptr - m_lat + D) % D);
            m_q_bx.push_back((m_bx - m_lat + 4096) % 4096);
          end
        end
        lbl = nt ? "R6" : (nv ? "R4" : "R5");
      end
      for (int p = 0; p < N; p++) m_mem[p][m_wptr] = {b_hit[p], b_toa[p], b_tot[p]};
      m_wptr = (m_wptr + 1) % D;
      m_bx = (m_bx + 1) % 4096;
    end
    @(negedge clk);
    chk(out_vld == nv, lbl, "out_vld", out_vld, nv);
    chk(out_trl == nt, lbl, "out_trl", out_trl, nt);
    chk(out_data == nd, lbl, "out_data", out_data, nd);
    chk(out_ovf == m_ovf[0], b_rst ? "R1" : "R8", "out_ovf", out_ovf, m_ovf);
    if (out_vld && out_trl) trl_seen++;
    if (out_vld && !out_trl) words_seen++;
  endtask

  task automatic drive_hits(int pct);
    for (int p = 0; p < N; p++) begin
      b_hit[p] = (($urandom % 100) < pct);
      b_toa[p] = 10'($urandom);
      b_tot[p] = 9'($urandom);
    end
  endtask

  task automatic run(int n, int pct, int l1a_pct);
    for (int i = 0; i < n; i++) begin
      drive_hits(pct);
      b_l1a = (($urandom % 100) < l1a_pct);
      step();
    end
    b_l1a = 1'b0;
  endtask

  task automatic do_reset(bit mode, int lat);
    b_mode = mode; b_lat = 5'(lat); b_rst = 1'b1;
    run(2, 0, 0);
    b_rst = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int t0, w0;
    for (int p = 0; p < N; p++) begin
      b_toa[p] = '0; b_tot[p] = '0;
      for (int k = 0; k < D; k++) m_mem[p][k] = '0;
    end
    // R1: reset state, diagnostic mode
    run(3, 50, 0);
    b_rst = 1'b0;
    // R2, R3: diagnostic stream with stray triggers
    t0 = trl_seen;
    run(40, 50, 20);
    b_dsel = 4'd12;
    run(20, 50, 20);
    chk(trl_seen == t0, "R3", "trailers in diagnostic mode", trl_seen, t0);
    chk(out_ovf == 1'b0, "R3", "ovf in diagnostic mode", out_ovf, 0);

    // R4, R5, R6: triggered mode, latency 8
    b_en = 16'hB5E7;
    do_reset(1'b1, 8);
    run(40, 40, 0);
    for (int k = 0; k < 5; k++) begin
      drive_hits(40); b_l1a = 1'b1; step(); b_l1a = 1'b0;
      run(25, 40, 0);
    end
    // R6: frame with no hits gives trailer only
    run(12, 0, 0);
    t0 = trl_seen; w0 = words_seen;
    drive_hits(0); b_l1a = 1'b1; step(); b_l1a = 1'b0;
    run(25, 0, 0);
    chk(trl_seen - t0 == 1, "R6", "trailer-only frame count", trl_seen - t0, 1);
    chk(words_seen == w0, "R6", "words in empty frame", words_seen - w0, 0);

    // R7: three accepts back to back
    run(10, 40, 0);
    t0 = trl_seen;
    for (int k = 0; k < 3; k++) begin drive_hits(40); b_l1a = 1'b1; step(); end
    b_l1a = 1'b0;
    run(70, 40, 0);
    chk(trl_seen - t0 == 3, "R7", "queued frames", trl_seen - t0, 3);
    chk(out_ovf == 1'b0, "R7", "ovf after queued accepts", out_ovf, 0);

    // R8: seven accepts in a row, five kept
    t0 = trl_seen;
    for (int k = 0; k < 7; k++) begin drive_hits(40); b_l1a = 1'b1; step(); end
    b_l1a = 1'b0;
    run(150, 40, 0);
    chk(trl_seen - t0 == 5, "R8", "frames after overflow", trl_seen - t0, 5);
    chk(out_ovf == 1'b1, "R8", "ovf after overflow", out_ovf, 1);

    // R9: mode and latency changes without reset are ignored
    b_mode = 1'b0; b_lat = 5'd3;
    run(5, 50, 0);
    chk(out_vld == 1'b0, "R9", "no diagnostic word without reset", out_vld, 0);
    drive_hits(50); b_l1a = 1'b1; step(); b_l1a = 1'b0;
    run(25, 50, 0);

    // R4 boundaries: latency 31 and 0, all pixels enabled
    b_en = 16'hFFFF;
    do_reset(1'b1, 31);
    chk(out_ovf == 1'b0, "R1", "ovf cleared by reset", out_ovf, 0);
    run(40, 30, 0);
    drive_hits(30); b_l1a = 1'b1; step(); b_l1a = 1'b0;
    run(25, 30, 0);
    b_en = 16'h8001;
    do_reset(1'b1, 0);
    run(40, 60, 0);
    drive_hits(100); b_l1a = 1'b1; step(); b_l1a = 1'b0;
    run(25, 60, 0);

    // R2 boundary: last pixel in diagnostic mode
    b_dsel = 4'd15;
    do_reset(1'b0, 0);
    run(10, 50, 30);

    done = 1;
    summary();
    $finish;
  end
endmodule